// File: doc/BRIEF.md
# Write-Guarded SPI Byte Memory

This block is an SPI slave in front of a 1024-byte, byte-addressed storage array. A host selects the device by pulling chip select low, sends a one-byte command, and for memory commands a two-byte address of which the low ten bits are used. Data then streams in or out, most significant bit first. Bits are captured on rising SCK edges and driven on falling SCK edges, so both idle-low (mode 0) and idle-high (mode 3) clocking work. The SPI pins are oversampled by the system clock. Each SCK half-period must last at least four system clock cycles. The serial link has no back-pressure of its own: the host paces every transfer, and the only flow control is the busy flag, which the host polls through the status command.

Writes pass three gates. The first is a write enable latch, set and cleared by commands. The second is an active-low protect pin that freezes the protection setting. The third is a lock field that marks one address region as read-only. A page write buffers up to 16 bytes; an address stepping past the end of its 16-byte page wraps to that page's first byte. When chip select rises after whole data bytes, an emulated internal write cycle starts and holds the busy flag for `BUSY_CYCLES` clocks. During that time the buffered bytes are copied into the array, and any byte that falls in the locked region is dropped.

Opcodes: 0x06 sets the latch, 0x04 clears it, 0x05 streams the status byte, 0x01 writes the status byte, 0x03 reads, and 0x02 writes. Status byte layout: bit 0 is busy, bit 1 is the latch, bits 4:2 are the lock code, and bits 7:5 read as zero. Lock codes: 0 means nothing is locked; 1 locks the first 16-byte page; 2 locks the last page; 3 locks the lower half of the array; 4 to 7 lock quarter 0 to 3, where quarter q covers addresses 256q to 256q+255.

Top module: `spi_guarded_eeprom`

## Requirements
- R1: After reset, the status byte reads 0x00: not busy, latch clear, lock code 0.
- R2: A 0x06 command sets status bit 1. A 0x04 command clears it.
- R3: A 0x02 write issued while the latch is clear changes no byte of the array and does not set the busy flag.
- R4: With the latch set, a 0x02 write followed by a 0x03 read at the same address returns the written bytes, and the read address advances by one for each byte.
- R5: Write data that steps past offset 15 of a page wraps to offset 0 of the same page; later bytes overwrite earlier ones.
- R6: A completed write holds status bit 0 high for BUSY_CYCLES clocks and clears the latch when the cycle ends. During that time, each data byte of a 0x03 read returns the status byte instead of array data.
- R7: A 0x01 command with the latch set loads bits 4:2 of its data byte as the lock code, which reads back in status bits 4:2. Written bytes that fall in the locked region are dropped, while writes outside it still land.
- R8: While wp_n is low, a 0x01 command leaves the lock code unchanged, starts no cycle and clears the latch.
- R9: A 0x02 or 0x01 command that ends before a whole data byte (mid-byte, or right after the address) writes nothing, starts no cycle and clears the latch.
- R10: While busy, every command except 0x05 and 0x03 is ignored, including 0x04.
- R11: Mode 0 and mode 3 transfers give the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select; its rising edge ends a transaction |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block; low while deselected |
| wp_n | input | 1 | Active-low protect pin that freezes the lock code |

## Verification
The bench checks page wrap with an 18-byte burst: a design that carried into the next page, or kept the first bytes at offsets 14 and 15, would show the wrong data at those offsets. It issues a read and a latch-clear command while busy. A design that served stale array data, or obeyed the clear command, would return array bytes or a status with bit 1 low. For four lock codes it checks one locked page and one free page, which exposes a wrong region decode in either direction. It also checks a status write with wp_n low, and transactions aborted mid-byte or right after the address. A design that leaked any of these would show a changed lock code, a set busy bit, a latch left set, or altered bytes.

// File: rtl/sge_pkg.sv
package sge_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_GET_ST  = 8'h05;
  localparam logic [7:0] OP_PUT_ST  = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  localparam int LOCK_W   = 3;
  localparam int LOCK_LSB = 2;

  localparam logic [LOCK_W-1:0] LK_NONE  = 3'd0;
  localparam logic [LOCK_W-1:0] LK_FIRST = 3'd1;
  localparam logic [LOCK_W-1:0] LK_LAST  = 3'd2;
  localparam logic [LOCK_W-1:0] LK_LOWER = 3'd3;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADRH,
    PH_ADRL,
    PH_RDAT,
    PH_WDAT,
    PH_SDAT,
    PH_STAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/sge_spi_link.sv
module sge_spi_link #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              cs_end_o,
  output logic              partial_o,
  output logic              rx_vld_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              tx_take_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic [2:0] sck_p;
  logic [2:0] cs_p;
  logic [1:0] mosi_p;
  logic       sck_rise, sck_fall, active;
  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              load_pend;

  // two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck_i};
      cs_p   <= {cs_p[1:0], cs_n_i};
      mosi_p <= {mosi_p[0], mosi_i};
    end
  end

  assign sck_rise  = sck_p[1] & ~sck_p[2];
  assign sck_fall  = ~sck_p[1] & sck_p[2];
  assign active    = ~cs_p[1];
  assign cs_end_o  = cs_p[1] & ~cs_p[2];
  assign partial_o = (bit_cnt != '0);
  assign tx_take_o = active & sck_fall & load_pend;
  assign miso_o    = active & tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      rx_vld_o  <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      rx_vld_o <= 1'b0;
      if (!active) begin
        bit_cnt   <= '0;
        tx_sh     <= '0;
        load_pend <= 1'b0;
      end else if (sck_rise) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], mosi_p[1]};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          load_pend <= 1'b1;
          rx_vld_o  <= 1'b1;
          rx_byte_o <= {rx_sh[BYTE_W-2:0], mosi_p[1]};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (sck_fall) begin
        if (load_pend) begin
          tx_sh     <= tx_byte_i;
          load_pend <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sge_block_guard.sv
module sge_block_guard
  import sge_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOCK_W-1:0] code_i,
  output logic              locked_o
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0] page;
  assign page = addr_i[ADDR_W-1:PAGE_W];

  always_comb begin
    case (code_i)
      LK_NONE:  locked_o = 1'b0;
      LK_FIRST: locked_o = (page == '0);
      LK_LAST:  locked_o = (page == '1);
      LK_LOWER: locked_o = ~addr_i[ADDR_W-1];
      default:  locked_o = (addr_i[ADDR_W-1:ADDR_W-2] == code_i[1:0]);
    endcase
  end
endmodule

// File: rtl/sge_page_buf.sv
module sge_page_buf #(
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_off_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [BYTE_W-1:0] slot_d [SLOTS];
  logic [SLOTS-1:0]  slot_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int i = 0; i < SLOTS; i++) slot_d[i] <= '0;
    end else if (clr_i) begin
      slot_v <= '0;
    end else if (wr_i) begin
      slot_d[wr_off_i] <= wr_data_i;
      slot_v[wr_off_i] <= 1'b1;
    end
  end

  assign rd_data_o = slot_d[rd_off_i];
  assign rd_vld_o  = slot_v[rd_off_i];
endmodule

// File: rtl/sge_mem_array.sv
module sge_mem_array #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/spi_guarded_eeprom.sv
module spi_guarded_eeprom
  import sge_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_n
);
  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  // serial link
  logic              cs_end, partial, rx_vld, tx_take;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  // control state
  phase_t            phase_q;
  logic              is_wr_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] off_q;
  logic              got_data_q;
  logic [LOCK_W-1:0] sr_new_q;
  logic              got_sr_q;
  logic              wel_q, busy_q;
  logic [CNT_W-1:0]  busy_cnt_q;
  logic [LOCK_W-1:0] lock_q;
  logic              cm_active_q;
  logic [PAGE_W-1:0] cm_idx_q;
  logic [PG_W-1:0]   cm_page_q;
  logic [1:0]        wp_p;
  logic              wp_s;

  // datapath
  logic              pb_clr, pb_wr, pb_vld;
  logic [BYTE_W-1:0] pb_data;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] mem_rdata;
  logic              mem_we, locked;
  logic [BYTE_W-1:0] status_byte;

  sge_spi_link #(.BYTE_W(BYTE_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_i     (spi_sck),
    .cs_n_i    (spi_cs_n),
    .mosi_i    (spi_mosi),
    .miso_o    (spi_miso),
    .cs_end_o  (cs_end),
    .partial_o (partial),
    .rx_vld_o  (rx_vld),
    .rx_byte_o (rx_byte),
    .tx_byte_i (tx_byte),
    .tx_take_o (tx_take)
  );

  sge_page_buf #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_pbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (pb_clr),
    .wr_i      (pb_wr),
    .wr_off_i  (off_q),
    .wr_data_i (rx_byte),
    .rd_off_i  (cm_idx_q),
    .rd_data_o (pb_data),
    .rd_vld_o  (pb_vld)
  );

  sge_block_guard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_guard (
    .addr_i   (mem_waddr),
    .code_i   (lock_q),
    .locked_o (locked)
  );

  sge_mem_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (pb_data),
    .raddr_i (addr_q),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_p <= 2'b11;
    else        wp_p <= {wp_p[0], wp_n};
  end
  assign wp_s = wp_p[1];

  assign status_byte = {3'b000, lock_q, wel_q, busy_q};
  assign pb_clr      = rx_vld && (phase_q == PH_ADRL) && is_wr_q;
  assign pb_wr       = rx_vld && (phase_q == PH_WDAT);
  assign mem_waddr   = {cm_page_q, cm_idx_q};
  assign mem_we      = cm_active_q && pb_vld && !locked;

  always_comb begin
    case (phase_q)
      PH_STAT: tx_byte = status_byte;
      PH_RDAT: tx_byte = mem_rdata;
      default: tx_byte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_CMD;
      is_wr_q     <= 1'b0;
      hi_q        <= '0;
      addr_q      <= '0;
      off_q       <= '0;
      got_data_q  <= 1'b0;
      sr_new_q    <= '0;
      got_sr_q    <= 1'b0;
      wel_q       <= 1'b0;
      busy_q      <= 1'b0;
      busy_cnt_q  <= '0;
      lock_q      <= LK_NONE;
      cm_active_q <= 1'b0;
      cm_idx_q    <= '0;
      cm_page_q   <= '0;
    end else begin
      // byte-level command sequencing
      if (rx_vld) begin
        case (phase_q)
          PH_CMD: begin
            case (rx_byte)
              OP_GET_ST: phase_q <= PH_STAT;
              OP_READ: begin
                is_wr_q <= 1'b0;
                phase_q <= busy_q ? PH_STAT : PH_ADRH;
              end
              OP_WRITE: begin
                is_wr_q <= 1'b1;
                phase_q <= busy_q ? PH_SKIP : PH_ADRH;
              end
              OP_PUT_ST: phase_q <= busy_q ? PH_SKIP : PH_SDAT;
              OP_SET_WEL: begin
                if (!busy_q) wel_q <= 1'b1;
                phase_q <= PH_SKIP;
              end
              OP_CLR_WEL: begin
                if (!busy_q) wel_q <= 1'b0;
                phase_q <= PH_SKIP;
              end
              default: phase_q <= PH_SKIP;
            endcase
          end
          PH_ADRH: begin
            hi_q    <= rx_byte[HI_W-1:0];
            phase_q <= PH_ADRL;
          end
          PH_ADRL: begin
            addr_q  <= {hi_q, rx_byte};
            off_q   <= rx_byte[PAGE_W-1:0];
            phase_q <= is_wr_q ? PH_WDAT : PH_RDAT;
          end
          PH_WDAT: begin
            off_q      <= off_q + 1'b1;
            got_data_q <= 1'b1;
          end
          PH_SDAT: begin
            if (!got_sr_q) sr_new_q <= rx_byte[LOCK_LSB +: LOCK_W];
            got_sr_q <= 1'b1;
          end
          default: ;
        endcase
      end

      // read pointer advances as each byte is handed to the shifter
      if (tx_take && phase_q == PH_RDAT) addr_q <= addr_q + 1'b1;

      // end of transaction
      if (cs_end) begin
        phase_q    <= PH_CMD;
        got_data_q <= 1'b0;
        got_sr_q   <= 1'b0;
        case (phase_q)
          PH_WDAT: begin
            if (wel_q && !partial && got_data_q) begin
              busy_q      <= 1'b1;
              busy_cnt_q  <= CNT_LOAD;
              cm_active_q <= 1'b1;
              cm_idx_q    <= '0;
              cm_page_q   <= addr_q[ADDR_W-1:PAGE_W];
            end else begin
              wel_q <= 1'b0;
            end
          end
          PH_SDAT: begin
            if (wel_q && !partial && got_sr_q && wp_s) begin
              lock_q     <= sr_new_q;
              busy_q     <= 1'b1;
              busy_cnt_q <= CNT_LOAD;
            end else begin
              wel_q <= 1'b0;
            end
          end
          PH_ADRH, PH_ADRL: begin
            if (is_wr_q) wel_q <= 1'b0;
          end
          default: ;
        endcase
      end

      // buffered bytes drain into the array during the cycle
      if (cm_active_q) begin
        cm_idx_q <= cm_idx_q + 1'b1;
        if (cm_idx_q == '1) cm_active_q <= 1'b0;
      end

      // emulated internal write cycle
      if (busy_q) begin
        if (busy_cnt_q == '0) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
        end else begin
          busy_cnt_q <= busy_cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sge_checker.sv
module sge_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic [2:0] lock,
  input logic       wp_s,
  input logic       mem_we,
  input logic       cs_end
);
  // R6: a write cycle only ever starts with the latch set
  a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R6: the latch is low once the cycle ends
  a_r6_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R8: protect pin low freezes the lock code
  a_r8_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |=> $stable(lock));

  // R7: the lock code changes only when a transaction ends
  a_r7_lock_at_cs_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock) |-> $past(cs_end));

  // R4: array writes happen only inside a write cycle
  a_r4_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R10: the latch cannot be set while a cycle is running
  a_r10_no_wel_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$rose(wel));
endmodule

bind spi_guarded_eeprom sge_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy_q),
  .wel    (wel_q),
  .lock   (lock_q),
  .wp_s   (wp_s),
  .mem_we (mem_we),
  .cs_end (cs_end)
);

// File: tb/spi_guarded_eeprom_bench.sv
module spi_guarded_eeprom_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic wp_n = 1'b1;
  logic mode3 = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] tx_buf [32];
  logic [7:0] rx_buf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_guarded_eeprom u_spi_guarded_eeprom (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .wp_n     (wp_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] o, input int nb, output logic [7:0] i);
    i = 8'h00;
    for (int b = 7; b >= 8 - nb; b--) begin
      if (mode3) spi_sck = 1'b0;
      spi_mosi = o[b];
      repeat (HALF) @(negedge clk);
      i[b] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!mode3) spi_sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_sck = mode3;
    repeat (2) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_txn(input int n);
    logic [7:0] r;
    cs_lo();
    for (int j = 0; j < n; j++) begin
      xbyte(tx_buf[j], 8, r);
      rx_buf[j] = r;
    end
    cs_hi();
  endtask

  task automatic cmd1(input logic [7:0] op);
    tx_buf[0] = op;
    run_txn(1);
  endtask

  task automatic rdsr(output logic [7:0] s);
    tx_buf[0] = 8'h05;
    tx_buf[1] = 8'h00;
    run_txn(2);
    s = rx_buf[1];
  endtask

  task automatic wrsr(input logic [7:0] v);
    tx_buf[0] = 8'h01;
    tx_buf[1] = v;
    run_txn(2);
  endtask

  task automatic write_bytes(input logic [9:0] a, input int n, input logic [7:0] base);
    tx_buf[0] = 8'h02;
    tx_buf[1] = {6'b0, a[9:8]};
    tx_buf[2] = a[7:0];
    for (int j = 0; j < n; j++) tx_buf[3+j] = base + 8'(j);
    run_txn(3 + n);
  endtask

  task automatic read_bytes(input logic [9:0] a, input int n);
    tx_buf[0] = 8'h03;
    tx_buf[1] = {6'b0, a[9:8]};
    tx_buf[2] = a[7:0];
    for (int j = 0; j < n; j++) tx_buf[3+j] = 8'h00;
    run_txn(3 + n);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic expect_run(input logic [9:0] a, input int n, input logic [7:0] base, input string req);
    int miss = 0;
    int first = 0;
    read_bytes(a, n);
    for (int j = 0; j < n; j++) begin
      if (rx_buf[3+j] !== base + 8'(j)) begin
        if (miss == 0) first = j;
        miss++;
      end
    end
    check(miss == 0, req, int'(rx_buf[3+first]), int'(base + 8'(first)));
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rdsr(s);
    check(s == 8'h00, "R1 status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06);
    rdsr(s);
    check(s == 8'h02, "R2 latch set", s, 8'h02);
    cmd1(8'h04);
    rdsr(s);
    check(s == 8'h00, "R2 latch cleared", s, 8'h00);
  endtask

  task automatic t_page_write();
    logic [7:0] s;
    cmd1(8'h06);
    write_bytes(10'h123, 4, 8'h50);
    wait_idle();
    rdsr(s);
    check(s == 8'h00, "R6 latch clear after cycle", s, 8'h00);
    expect_run(10'h123, 4, 8'h50, "R4 page write readback");
  endtask

  task automatic t_no_latch();
    logic [7:0] s;
    write_bytes(10'h123, 2, 8'hE0);
    rdsr(s);
    check(s == 8'h00, "R3 no cycle without latch", s, 8'h00);
    expect_run(10'h123, 2, 8'h50, "R3 array unchanged");
  endtask

  task automatic t_wrap();
    int miss = 0;
    int exp = 0;
    int act = 0;
    cmd1(8'h06);
    write_bytes(10'h20E, 18, 8'h30);
    wait_idle();
    read_bytes(10'h200, 16);
    for (int k = 0; k < 16; k++) begin
      int e;
      e = (k < 14) ? (8'h32 + k) : (8'h40 + k - 14);
      if (rx_buf[3+k] !== 8'(e)) begin
        if (miss == 0) begin
          exp = e;
          act = int'(rx_buf[3+k]);
        end
        miss++;
      end
    end
    check(miss == 0, "R5 wrap inside page", act, exp);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    cmd1(8'h06);
    write_bytes(10'h0A0, 1, 8'h77);
    rdsr(s);
    check(s == 8'h03, "R6 busy with latch held", s, 8'h03);
    read_bytes(10'h0A0, 2);
    check(rx_buf[3] == 8'h03 && rx_buf[4] == 8'h03, "R6 read while busy gives status",
          {rx_buf[3], rx_buf[4]}, 16'h0303);
    cmd1(8'h04);
    rdsr(s);
    check(s == 8'h03, "R10 latch clear ignored while busy", s, 8'h03);
    wait_idle();
    rdsr(s);
    check(s == 8'h00, "R6 cycle ends and latch clears", s, 8'h00);
    expect_run(10'h0A0, 1, 8'h77, "R6 byte stored");
  endtask

  task automatic set_lock(input logic [2:0] code);
    logic [7:0] s;
    cmd1(8'h06);
    wrsr({3'b000, code, 2'b00});
    wait_idle();
    rdsr(s);
    check(s == {3'b000, code, 2'b00}, "R7 lock code in status", s, {3'b000, code, 2'b00});
  endtask

  task automatic guarded_write(input logic [9:0] a, input logic [7:0] base);
    cmd1(8'h06);
    write_bytes(a, 4, base);
    wait_idle();
  endtask

  task automatic t_lock();
    guarded_write(10'h000, 8'h10);
    guarded_write(10'h3F0, 8'h20);
    guarded_write(10'h100, 8'h40);
    guarded_write(10'h300, 8'h60);
    // code 1: first page
    set_lock(3'd1);
    guarded_write(10'h000, 8'hC0);
    expect_run(10'h000, 4, 8'h10, "R7 first page locked");
    guarded_write(10'h080, 8'h81);
    expect_run(10'h080, 4, 8'h81, "R7 free page written, code 1");
    // code 2: last page
    set_lock(3'd2);
    guarded_write(10'h3F0, 8'hC0);
    expect_run(10'h3F0, 4, 8'h20, "R7 last page locked");
    guarded_write(10'h080, 8'h91);
    expect_run(10'h080, 4, 8'h91, "R7 free page written, code 2");
    // code 3: lower half
    set_lock(3'd3);
    guarded_write(10'h100, 8'hC0);
    expect_run(10'h100, 4, 8'h40, "R7 lower half locked");
    guarded_write(10'h200, 8'hA1);
    expect_run(10'h200, 4, 8'hA1, "R7 upper half written, code 3");
    // code 7: top quarter
    set_lock(3'd7);
    guarded_write(10'h300, 8'hC0);
    expect_run(10'h300, 4, 8'h60, "R7 quarter 3 locked");
    guarded_write(10'h080, 8'hB1);
    expect_run(10'h080, 4, 8'hB1, "R7 free page written, code 7");
    set_lock(3'd0);
  endtask

  task automatic t_protect_pin();
    logic [7:0] s;
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd1(8'h06);
    wrsr(8'h14);
    rdsr(s);
    check(s == 8'h00, "R8 status write blocked by pin", s, 8'h00);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    set_lock(3'd5);
    set_lock(3'd0);
  endtask

  task automatic t_abort();
    logic [7:0] s;
    logic [7:0] r;
    cmd1(8'h06);
    cs_lo();
    xbyte(8'h02, 8, r);
    xbyte(8'h01, 8, r);
    xbyte(8'h23, 8, r);
    xbyte(8'hEE, 8, r);
    xbyte(8'hA5, 3, r);
    cs_hi();
    rdsr(s);
    check(s == 8'h00, "R9 mid-byte abort", s, 8'h00);
    expect_run(10'h123, 1, 8'h50, "R9 array unchanged after abort");
    cmd1(8'h06);
    tx_buf[0] = 8'h02;
    tx_buf[1] = 8'h01;
    tx_buf[2] = 8'h23;
    run_txn(3);
    rdsr(s);
    check(s == 8'h00, "R9 abort after address", s, 8'h00);
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    mode3 = 1'b1;
    cmd1(8'h06);
    rdsr(s);
    check(s == 8'h02, "R11 mode 3 latch set", s, 8'h02);
    write_bytes(10'h1F0, 3, 8'h90);
    wait_idle();
    expect_run(10'h1F0, 3, 8'h90, "R11 mode 3 write and read");
    mode3 = 1'b0;
    expect_run(10'h1F0, 3, 8'h90, "R11 mode 0 reads mode 3 data");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_page_write();
    t_no_latch();
    t_wrap();
    t_busy();
    t_lock();
    t_protect_pin();
    t_abort();
    t_mode3();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule